// File: doc/BRIEF.md
# Urgency-Driven Context Switch Controller

This controller sits beside a core that holds two hardware thread contexts but issues from only one of them at a time. Each context carries a 3-bit urgency score, and the score moves with what happens to that thread. A long-latency miss lowers it by one step. The return of miss data puts it back to the nominal value of 5. An interrupt aimed at the thread lifts it to 6. A fairness timer lifts it to 7 once the thread has waited in the background for too long.

The pipeline belongs to one thread at a time. Ownership passes to the other thread in two cases: the owner's score is strictly below the waiting thread's score, or software running on the owner asks to yield. Each handover happens in three steps. First a one-cycle flush pulse goes to the pipeline. On the next cycle the active-thread output flips and a one-cycle switch pulse marks the new owner. After every handover decision a hold-off window runs, so that the two threads cannot bounce the pipeline back and forth while it drains.

The cache, the pipeline and the register files are outside this block. They reach it only through the event inputs, and they follow its flush, switch and active-thread outputs.

Top module: `cgmt_urgency_switch`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `active_o` is 0 (thread 0 owns the pipeline), `flush_o` and `switch_o` are 0, and both threads have urgency 5.
- R2: A pulse on bit t of `miss_i` lowers thread t's urgency by one at the next clock edge. It does not go below 0: a miss taken at urgency 0 leaves it at 0.
- R3: A pulse on bit t of `fill_i` sets thread t's urgency to 5 at the next clock edge.
- R4: A pulse on bit t of `irq_i` sets thread t's urgency to 6 at the next clock edge.
- R5: Each thread has a wait counter. It is cleared on every handover. It counts each cycle in which the thread is in the background and no flush is in progress. At the edge that ends the TMO_CYCLES-th counted cycle, the thread's urgency becomes 7. The counter then stays at its limit until the next handover.
- R6: With no hold-off running and no flush in progress, a handover is decided at a clock edge when the active thread's urgency is strictly below the other thread's urgency. Equal urgencies never cause a handover.
- R7: `yield_i` high at an edge with no hold-off running and no flush in progress decides a handover, whatever the urgencies are.
- R8: A handover decided at edge E drives `flush_o` high for exactly the cycle after E. At edge E+1 `active_o` inverts and `switch_o` goes high for exactly one cycle. `active_o` changes at no other time.
- R9: A decision loads a hold-off of HOLDOFF cycles. The next decision is made no earlier than HOLDOFF+1 edges later, so two `flush_o` pulses are always at least HOLDOFF+1 cycles apart. A `yield_i` seen while hold-off or flush is active is dropped. An urgency imbalance is acted on once the hold-off has ended.
- R10: At the handover edge, the thread that gains the pipeline has its urgency reset to 5 if it was above 5. If it was at 5 or below, its urgency is left unchanged.
- R11: When several updates hit the same thread at one edge, the first applicable one in this list wins: timeout (7), interrupt (6), gain restore (5), data return (5), miss (minus one).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_i | input | 2 | Per-thread long-latency miss event, one bit per thread |
| fill_i | input | 2 | Per-thread miss data return event |
| irq_i | input | 2 | Per-thread external interrupt event |
| yield_i | input | 1 | Software request from the active thread to give up the pipeline |
| flush_o | output | 1 | One-cycle pipeline flush pulse that precedes a handover |
| switch_o | output | 1 | One-cycle pulse in the first cycle of the new owner |
| active_o | output | 1 | Identifier of the thread that owns the pipeline |

## Verification
An urgency event sampled at edge E0 first shows on `flush_o` after edge E1 and on `active_o`/`switch_o` after edge E2. A yield shows one edge earlier: flush after E0, flip after E1. A fairness timeout decides at the edge after the urgency rise, so the flip comes two edges after the TMO_CYCLES-th counted wait cycle. The bench drives inputs on falling edges and samples on falling edges. Directed checks are placed at those exact falling edges. A behavioural model, stepped on each rising edge, predicts all three outputs and is compared on every falling edge. A separate monitor measures the spacing of flush pulses against the hold-off.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;
  localparam int NT    = 2;
  localparam int URG_W = 3;

  typedef logic [URG_W-1:0] urg_t;

  localparam urg_t URG_NOM = 3'd5;
  localparam urg_t URG_IRQ = 3'd6;
  localparam urg_t URG_MAX = 3'd7;
  localparam urg_t URG_MIN = 3'd0;
endpackage

// File: rtl/cgmt_wait_timer.sv
module cgmt_wait_timer #(
  parameter int TMO_CYCLES = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_i,
  input  logic clr_i,
  output logic fire_o
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);
  localparam logic [CW-1:0] CNT_LIM  = CW'(TMO_CYCLES);

  logic [CW-1:0] cnt_q;

  assign fire_o = wait_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (wait_i && (cnt_q != CNT_LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TMO_SINGLE_FIRE: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !fire_o); // R5
  AST_TMO_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/cgmt_urgency_track.sv
module cgmt_urgency_track
  import cgmt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tmo_i,
  input  logic irq_i,
  input  logic gain_i,
  input  logic fill_i,
  input  logic miss_i,
  output urg_t urg_o
);
  urg_t urg_d;

  always_comb begin
    urg_d = urg_o;
    if (tmo_i) begin
      urg_d = URG_MAX;
    end else if (irq_i) begin
      urg_d = URG_IRQ;
    end else if (gain_i && (urg_o > URG_NOM)) begin
      urg_d = URG_NOM;
    end else if (fill_i) begin
      urg_d = URG_NOM;
    end else if (miss_i) begin
      urg_d = (urg_o == URG_MIN) ? URG_MIN : urg_o - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) urg_o <= URG_NOM;
    else     urg_o <= urg_d;
  end

  AST_TMO_TO_MAX: assert property (@(posedge clk) disable iff (rst)
    tmo_i |=> (urg_o == URG_MAX)); // R5
  AST_IRQ_TO_SIX: assert property (@(posedge clk) disable iff (rst)
    (irq_i && !tmo_i) |=> (urg_o == URG_IRQ)); // R4
  AST_FILL_TO_NOM: assert property (@(posedge clk) disable iff (rst)
    (fill_i && !tmo_i && !irq_i) |=> (urg_o == URG_NOM)); // R3
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    (miss_i && !tmo_i && !irq_i && !gain_i && !fill_i) |=>
      (urg_o == (($past(urg_o) == URG_MIN) ? URG_MIN : urg_t'($past(urg_o) - 1'b1)))); // R2
  AST_GAIN_CAPS: assert property (@(posedge clk) disable iff (rst)
    (gain_i && !tmo_i && !irq_i) |=> (urg_o <= URG_NOM)); // R10
endmodule

// File: rtl/cgmt_switch_seq.sv
module cgmt_switch_seq
  import cgmt_pkg::*;
#(
  parameter int HOLDOFF = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  urg_t [NT-1:0]     urg_i,
  input  logic              yield_i,
  output logic              flush_o,
  output logic              switch_o,
  output logic              active_o
);
  localparam int HW = $clog2(HOLDOFF + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLDOFF);

  logic [HW-1:0] hold_q;
  logic [HW-1:0] gap_q;
  urg_t          fg_urg;
  urg_t          bg_urg;
  logic          decide;

  always_comb begin
    fg_urg = urg_i[active_o];
    bg_urg = urg_i[~active_o];
    decide = !flush_o && (hold_q == '0) && (yield_i || (fg_urg < bg_urg));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_o  <= 1'b0;
      switch_o <= 1'b0;
      active_o <= 1'b0;
      hold_q   <= '0;
    end else begin
      flush_o  <= decide;
      switch_o <= flush_o;
      if (flush_o) active_o <= ~active_o;
      if (decide)              hold_q <= HOLD_LOAD;
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end
  end

  // spacing tracker for the hold-off property
  always_ff @(posedge clk) begin
    if (rst)                    gap_q <= HOLD_LOAD;
    else if (flush_o)           gap_q <= HW'(1);
    else if (gap_q != HOLD_LOAD) gap_q <= gap_q + 1'b1;
  end

  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o); // R8
  AST_FLIP_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> (switch_o && (active_o != $past(active_o)))); // R8
  AST_SWITCH_NEEDS_FLUSH: assert property (@(posedge clk) disable iff (rst)
    switch_o |-> $past(flush_o)); // R8
  AST_OWNER_STABLE: assert property (@(posedge clk) disable iff (rst)
    !switch_o |-> $stable(active_o)); // R8
  AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(flush_o) |-> (gap_q >= HOLD_LOAD)); // R9
endmodule

// File: rtl/cgmt_urgency_switch.sv
module cgmt_urgency_switch
  import cgmt_pkg::*;
#(
  parameter int TMO_CYCLES = 256,
  parameter int HOLDOFF    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] miss_i,
  input  logic [NT-1:0] fill_i,
  input  logic [NT-1:0] irq_i,
  input  logic          yield_i,
  output logic          flush_o,
  output logic          switch_o,
  output logic          active_o
);
  urg_t [NT-1:0] urg_w;
  logic [NT-1:0] fire_w;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic is_bg;
    assign is_bg = (active_o != 1'(t));

    cgmt_wait_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .wait_i (is_bg && !flush_o),
      .clr_i  (flush_o),
      .fire_o (fire_w[t])
    );

    cgmt_urgency_track u_urg (
      .clk    (clk),
      .rst    (rst),
      .tmo_i  (fire_w[t]),
      .irq_i  (irq_i[t]),
      .gain_i (flush_o && is_bg),
      .fill_i (fill_i[t]),
      .miss_i (miss_i[t]),
      .urg_o  (urg_w[t])
    );
  end

  cgmt_switch_seq #(.HOLDOFF(HOLDOFF)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .urg_i    (urg_w),
    .yield_i  (yield_i),
    .flush_o  (flush_o),
    .switch_o (switch_o),
    .active_o (active_o)
  );

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(flush_o && switch_o)); // R8
  AST_RESET_OWNER: assert property (@(posedge clk)
    rst |=> (!active_o && !flush_o && !switch_o)); // R1
  AST_FG_TIMER_SILENT: assert property (@(posedge clk) disable iff (rst)
    !fire_w[active_o]); // R5
endmodule

// File: tb/cgmt_urgency_switch_tb.sv
module cgmt_urgency_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO  = 40;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] miss_i = '0, fill_i = '0, irq_i = '0;
  logic       yield_i = 1'b0;
  logic       flush_o, switch_o, active_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cgmt_urgency_switch #(.TMO_CYCLES(TMO), .HOLDOFF(HOLD)) u_dut (
    .clk(clk), .rst(rst), .miss_i(miss_i), .fill_i(fill_i), .irq_i(irq_i),
    .yield_i(yield_i), .flush_o(flush_o), .switch_o(switch_o), .active_o(active_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // behavioural reference, advanced on each rising edge
  int m_act, m_pend, m_sw, m_hold;
  int m_urg [2];
  int m_cnt [2];

  always @(posedge clk) begin
    int fg, bg, dec;
    int nu [2];
    int nc [2];
    if (rst) begin
      m_act = 0; m_pend = 0; m_sw = 0; m_hold = 0;
      m_urg[0] = 5; m_urg[1] = 5; m_cnt[0] = 0; m_cnt[1] = 0;
    end else begin
      fg  = m_act;
      bg  = 1 - m_act;
      dec = (m_pend == 0 && m_hold == 0 && (yield_i || m_urg[fg] < m_urg[bg])) ? 1 : 0;
      for (int t = 0; t < 2; t++) begin
        nu[t] = m_urg[t];
        if (t == bg && m_pend == 0 && m_cnt[t] == TMO - 1) nu[t] = 7;
        else if (irq_i[t]) nu[t] = 6;
        else if (m_pend != 0 && t == bg && m_urg[t] > 5) nu[t] = 5;
        else if (fill_i[t]) nu[t] = 5;
        else if (miss_i[t]) nu[t] = (m_urg[t] > 0) ? m_urg[t] - 1 : 0;
        nc[t] = m_cnt[t];
        if (m_pend != 0) nc[t] = 0;
        else if (t == bg && m_cnt[t] < TMO) nc[t] = m_cnt[t] + 1;
      end
      m_urg[0] = nu[0]; m_urg[1] = nu[1];
      m_cnt[0] = nc[0]; m_cnt[1] = nc[1];
      if (dec != 0) m_hold = HOLD;
      else if (m_hold > 0) m_hold = m_hold - 1;
      m_sw = m_pend;
      if (m_pend != 0) m_act = bg;
      m_pend = dec;
    end
  end

  // per-cycle comparison and hold-off spacing monitor
  int gap  = 0;
  bit seen = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 model flush_o", int'(flush_o), m_pend);
      chk("R8 model switch_o", int'(switch_o), m_sw);
      chk("R6 model active_o", int'(active_o), m_act);
      gap++;
      if (flush_o) begin
        if (seen) chk("R9 flush spacing ok", (gap >= HOLD + 1) ? 1 : 0, 1);
        gap  = 0;
        seen = 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual %0d cycles expected below 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) tick();
    chk("R1 reset active_o", int'(active_o), 0);
    chk("R1 reset flush_o", int'(flush_o), 0);
    chk("R1 reset switch_o", int'(switch_o), 0);
    rst = 1'b0;
    tick();
    chk("R1 owner after reset", int'(active_o), 0);

    // equal urgencies: nothing moves
    repeat (10) tick();
    chk("R6 equal urgency no handover", int'(active_o), 0);
    chk("R6 equal urgency no flush", int'(flush_o), 0);

    // miss on owner: 4 < 5
    miss_i[0] = 1'b1; tick(); miss_i[0] = 1'b0;
    tick();
    chk("R2 miss gives flush", int'(flush_o), 1);
    chk("R8 owner unchanged during flush", int'(active_o), 0);
    tick();
    chk("R8 owner flipped", int'(active_o), 1);
    chk("R8 switch pulse", int'(switch_o), 1);
    tick();
    chk("R8 switch pulse ends", int'(switch_o), 0);

    // data return brings thread 0 back to 5, then a miss on thread 1
    repeat (6) tick();
    fill_i[0] = 1'b1; tick(); fill_i[0] = 1'b0;
    repeat (8) tick();
    chk("R6 equal after return", int'(active_o), 1);
    miss_i[1] = 1'b1; tick(); miss_i[1] = 1'b0;
    tick(); tick();
    chk("R3 return restored nominal", int'(active_o), 0);

    // yield, then automatic return after hold-off (thread 1 at 4)
    repeat (6) tick();
    yield_i = 1'b1; tick(); yield_i = 1'b0;
    chk("R7 yield flush", int'(flush_o), 1);
    tick();
    chk("R7 yield handover", int'(active_o), 1);
    repeat (3) tick();
    chk("R9 no decision inside hold-off", int'(flush_o), 0);
    tick();
    chk("R9 decision after hold-off", int'(flush_o), 1);
    tick();
    chk("R9 back to thread 0", int'(active_o), 0);

    // floor at 0 for thread 1 (4 -> 0, six misses)
    repeat (6) tick();
    for (int k = 0; k < 6; k++) begin
      miss_i[1] = 1'b1; tick(); miss_i[1] = 1'b0; tick();
    end
    chk("R2 floor keeps owner", int'(active_o), 0);
    chk("R2 floor no flush", int'(flush_o), 0);

    // interrupt lifts thread 1 to 6, restore to 5 on gain
    irq_i[1] = 1'b1; tick(); irq_i[1] = 1'b0;
    tick();
    chk("R4 interrupt flush", int'(flush_o), 1);
    tick();
    chk("R4 interrupt handover", int'(active_o), 1);
    repeat (8) tick();
    chk("R10 owner kept at equal", int'(active_o), 1);
    miss_i[1] = 1'b1; tick(); miss_i[1] = 1'b0;
    tick(); tick();
    chk("R10 restored urgency lets miss hand over", int'(active_o), 0);
    chk("R8 switch on return", int'(switch_o), 1);

    // fairness timeout for waiting thread 1 (at 4)
    repeat (30) tick();
    chk("R5 no timeout yet", int'(active_o), 0);
    repeat (15) tick();
    chk("R5 timeout handover", int'(active_o), 1);

    // priority: interrupt beats miss on thread 0
    repeat (3) tick();
    irq_i[0] = 1'b1; miss_i[0] = 1'b1; tick(); irq_i[0] = 1'b0; miss_i[0] = 1'b0;
    tick(); tick();
    chk("R11 interrupt over miss", int'(active_o), 0);

    // priority: return beats miss on owner
    repeat (6) tick();
    fill_i[0] = 1'b1; miss_i[0] = 1'b1; tick(); fill_i[0] = 1'b0; miss_i[0] = 1'b0;
    repeat (6) tick();
    chk("R11 return over miss", int'(active_o), 0);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      for (int t = 0; t < 2; t++) begin
        miss_i[t] = ($urandom_range(0, 7) == 0);
        fill_i[t] = ($urandom_range(0, 9) == 0);
        irq_i[t]  = ($urandom_range(0, 39) == 0);
      end
      yield_i = ($urandom_range(0, 29) == 0);
      tick();
    end
    miss_i = '0; fill_i = '0; irq_i = '0; yield_i = 1'b0;
    repeat (5) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule